// File: doc/BRIEF.md
# Integer Store Decode and Update Unit

This block sits in a 32-bit load/store pipeline and turns an already-decoded integer store into a memory write request. It forms the effective address and selects a store width of byte, halfword or word. It places the source data on the right big-endian byte lanes and raises the matching byte enables. For the update variants it also emits a register-file write of the effective address into the base register. Instructions that are architecturally malformed are flagged and neither write memory nor update a register. A halfword or word store at an address that is not naturally aligned is flagged as misaligned and is suppressed in the same way.

Instructions enter through a valid/ready handshake. Each accepted instruction is held in a one-entry result slot that a two-state machine tracks. In `ST_EMPTY` the slot holds nothing and `in_ready` is high. An accepted instruction moves the slot to `ST_FULL`. In `ST_FULL` the result is offered on the output side. It leaves when `out_ready` is high. A new instruction may be loaded in that same cycle, so the slot stays in `ST_FULL`. With no new instruction, the slot returns to `ST_EMPTY`. The store data is captured when the instruction is accepted. The register writeback is issued only in the cycle the store request is taken. Because of this, a store whose source and base registers are the same stores the old register value, and the update lands afterwards.

Top module: `isd_store_unit`

## Requirements
- R1: For the displacement forms (`in_indexed`=0), the address is the base plus the 16-bit `in_disp` sign-extended to 32 bits. The base is `in_ra_val`, except that it is zero when `in_ra_idx` is 0.
- R2: For the indexed forms (`in_indexed`=1), the address is the base (as in R1) plus `in_rb_val`.
- R3: `in_size` code 0 selects a byte store. Bit i of `mem_be` covers `mem_wdata[8i+7:8i]`, and address offset k (address bits 1:0) maps to lane 3-k. Byte enables are `4'b1000 >> k`, and the low source byte is copied into all four lanes.
- R4: `in_size` code 1 selects a halfword store. Offset 0 gives `4'b1100` and offset 2 gives `4'b0011`. The low source halfword is copied into both halves of `mem_wdata`.
- R5: `in_size` code 2 selects a word store at offset 0, with `mem_be` = `4'b1111` and `mem_wdata` equal to `in_rs_val`.
- R6: An update store (`in_update`=1) with a nonzero base index that is neither malformed nor misaligned raises `wb_valid`. This happens in the cycle the request is taken (`out_valid` and `out_ready` both high), with `wb_idx` equal to the base index and `wb_data` equal to `mem_addr`. Non-update stores never raise `wb_valid`.
- R7: When source and base are the same register in an update store, `mem_wdata` carries the register value from before the update, and `wb_data` carries the new address.
- R8: An update store with base index 0 sets `bad_form`, and `mem_we`, `wb_valid` and `mem_be` stay 0.
- R9: A store with the record bit (`in_record`) set, or with `in_size` code 3, sets `bad_form`, with no memory write, no writeback and zero byte enables.
- R10: A well-formed halfword at an odd offset, or a well-formed word at a nonzero offset, sets `misalign`. `mem_we`, `wb_valid` and `mem_be` stay 0.
- R11: `in_ready` is high when the slot is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, every output of the slot stays unchanged and no new instruction is taken.
- R12: During reset and right after it, `out_valid`, `mem_we` and `wb_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded store instruction present |
| in_ready | output | 1 | Block can take an instruction this cycle |
| in_size | input | 2 | Width code: 0 byte, 1 halfword, 2 word, 3 reserved |
| in_indexed | input | 1 | 1: register+register address, 0: register+displacement |
| in_update | input | 1 | Update variant: write address back to base register |
| in_record | input | 1 | Record bit of the instruction word |
| in_ra_idx | input | 5 | Base register index |
| in_disp | input | 16 | Signed displacement |
| in_ra_val | input | 32 | Base register read value |
| in_rb_val | input | 32 | Index register read value |
| in_rs_val | input | 32 | Source register read value |
| out_valid | output | 1 | Result slot full |
| out_ready | input | 1 | Consumer takes the result this cycle |
| mem_we | output | 1 | Request is a real memory write |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_be | output | 4 | Byte enables, big-endian lane order |
| bad_form | output | 1 | Instruction is a malformed store |
| misalign | output | 1 | Halfword or word not naturally aligned |
| wb_valid | output | 1 | Base register writeback this cycle |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 32 | Writeback value (the effective address) |

## Verification
The assertions are checked on every clock. They cover the following:
- malformed and misaligned results never write memory or registers;
- a writeback occurs only while the request is being taken, and it carries the address to a nonzero register;
- a stalled result holds still;
- an enabled write has one, two or four byte enables.

Only the bench's scenarios can confirm the actual address arithmetic, the lane placement for each offset, and the zero base for index 0. The same holds for the old-value-stored ordering when source and base are the same register, and for an instruction offered during a stall being taken only after the stall ends. The bench sweeps every width code, form, record bit, two base indices and all four address offsets, and computes each expected value arithmetically.

// File: rtl/isd_pkg.sv
package isd_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } st_size_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/isd_ea_calc.sv
module isd_ea_calc #(
    parameter int XLEN   = 32,
    parameter int DISP_W = 16
) (
    input  logic              zero_base,
    input  logic              indexed,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   index_val,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   ea
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] base_sel;
    logic [XLEN-1:0] offs_sel;

    always_comb begin
        base_sel = zero_base ? '0 : base_val;
        offs_sel = indexed ? index_val : {{EXT_W{disp[DISP_W-1]}}, disp};
        ea       = base_sel + offs_sel;
    end
endmodule

// File: rtl/isd_lane_gen.sv
module isd_lane_gen
    import isd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  st_size_e                     size,
    input  logic [$clog2(XLEN/8)-1:0]    off,
    input  logic [XLEN-1:0]              src,
    output logic [XLEN/8-1:0]            be,
    output logic [XLEN-1:0]              wdata,
    output logic                         unaligned
);
    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);

    always_comb begin
        unaligned = ((size == SZ_HALF) && off[0]) ||
                    ((size == SZ_WORD) && (off != '0));
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int          K     = LANES - 1 - l;
        localparam logic [OFF_W-1:0] KV = K[OFF_W-1:0];
        logic       lane_en;
        logic [7:0] lane_byte;

        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    lane_en   = (off == KV);
                    lane_byte = src[7:0];
                end
                SZ_HALF: begin
                    lane_en   = (off[OFF_W-1:1] == KV[OFF_W-1:1]);
                    lane_byte = src[(l % 2) * 8 +: 8];
                end
                SZ_WORD: begin
                    lane_en   = 1'b1;
                    lane_byte = src[l * 8 +: 8];
                end
                default: begin
                    lane_en   = 1'b0;
                    lane_byte = 8'h00;
                end
            endcase
        end

        assign be[l]            = lane_en;
        assign wdata[l*8 +: 8]  = lane_byte;
    end
endmodule

// File: rtl/isd_store_unit.sv
module isd_store_unit
    import isd_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int DISP_W = 16,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_size,
    input  logic              in_indexed,
    input  logic              in_update,
    input  logic              in_record,
    input  logic [RIDX_W-1:0] in_ra_idx,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [XLEN-1:0]   in_ra_val,
    input  logic [XLEN-1:0]   in_rb_val,
    input  logic [XLEN-1:0]   in_rs_val,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic [XLEN/8-1:0] mem_be,
    output logic              bad_form,
    output logic              misalign,
    output logic              wb_valid,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]   wb_data
);
    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);

    // ---------------- decode of the incoming instruction ----------------
    st_size_e          size_d;
    logic              ra_zero;
    logic              form_bad;
    logic [XLEN-1:0]   ea_d;
    logic [LANES-1:0]  lane_be;
    logic [XLEN-1:0]   lane_data;
    logic              lane_unal;
    logic              store_ok;
    logic              upd_ok;

    always_comb begin
        size_d   = st_size_e'(in_size);
        ra_zero  = (in_ra_idx == '0);
        form_bad = in_record || (size_d == SZ_RSVD) || (in_update && ra_zero);
        store_ok = !form_bad && !lane_unal;
        upd_ok   = store_ok && in_update;
    end

    isd_ea_calc #(.XLEN(XLEN), .DISP_W(DISP_W)) u_ea (
        .zero_base (ra_zero),
        .indexed   (in_indexed),
        .base_val  (in_ra_val),
        .index_val (in_rb_val),
        .disp      (in_disp),
        .ea        (ea_d)
    );

    isd_lane_gen #(.XLEN(XLEN)) u_lane (
        .size      (size_d),
        .off       (ea_d[OFF_W-1:0]),
        .src       (in_rs_val),
        .be        (lane_be),
        .wdata     (lane_data),
        .unaligned (lane_unal)
    );

    // ---------------- result slot state machine ----------------
    slot_state_e       state_q, state_d;
    logic              accept;

    logic [XLEN-1:0]   addr_q;
    logic [XLEN-1:0]   wdata_q;
    logic [LANES-1:0]  be_q;
    logic              bad_q;
    logic              mis_q;
    logic              we_q;
    logic              upd_q;
    logic [RIDX_W-1:0] ridx_q;

    assign in_ready = (state_q == ST_EMPTY) || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)               state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
            default:                              state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // payload captured at acceptance: store data is the pre-update value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            bad_q   <= 1'b0;
            mis_q   <= 1'b0;
            we_q    <= 1'b0;
            upd_q   <= 1'b0;
            ridx_q  <= '0;
        end else if (accept) begin
            addr_q  <= ea_d;
            wdata_q <= lane_data;
            be_q    <= store_ok ? lane_be : '0;
            bad_q   <= form_bad;
            mis_q   <= lane_unal && !form_bad;
            we_q    <= store_ok;
            upd_q   <= upd_ok;
            ridx_q  <= in_ra_idx;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        out_valid = (state_q == ST_FULL);
        mem_we    = out_valid && we_q;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        mem_be    = be_q;
        bad_form  = out_valid && bad_q;
        misalign  = out_valid && mis_q;
        wb_valid  = out_valid && out_ready && upd_q;
        wb_idx    = ridx_q;
        wb_data   = addr_q;
    end
endmodule

// File: rtl/isd_store_unit_chk.sv
module isd_store_unit_chk #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              mem_we,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN-1:0]   mem_wdata,
    input logic [XLEN/8-1:0] mem_be,
    input logic              bad_form,
    input logic              misalign,
    input logic              wb_valid,
    input logic [RIDX_W-1:0] wb_idx,
    input logic [XLEN-1:0]   wb_data
);
    // R12: reset clears the slot
    assert_reset_clear_R12: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !mem_we && !wb_valid));

    // R8 / R9: malformed store does nothing
    assert_bad_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_form |-> (!mem_we && !wb_valid && mem_be == '0));

    // R10: misaligned store does nothing
    assert_misalign_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_we && !wb_valid && mem_be == '0));

    // R6: writeback only on the taken request, to a nonzero register, carrying the address
    assert_wb_on_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (out_valid && out_ready && mem_we && wb_idx != '0 && wb_data == mem_addr));

    // R11: stalled result holds
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(mem_addr) && $stable(mem_wdata)
                                       && $stable(mem_be) && $stable(mem_we)));

    // R11: no acceptance while stalled
    assert_stall_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R3 / R4 / R5: an enabled write covers 1, 2 or 4 lanes
    assert_be_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                    $countones(mem_be) == 4));
endmodule

bind isd_store_unit isd_store_unit_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .bad_form  (bad_form),
    .misalign  (misalign),
    .wb_valid  (wb_valid),
    .wb_idx    (wb_idx),
    .wb_data   (wb_data)
);

// File: tb/tb_isd_store_unit.sv
module tb_isd_store_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_size = '0;
    logic        in_indexed = 1'b0;
    logic        in_update = 1'b0;
    logic        in_record = 1'b0;
    logic [4:0]  in_ra_idx = '0;
    logic [15:0] in_disp = '0;
    logic [31:0] in_ra_val = '0;
    logic [31:0] in_rb_val = '0;
    logic [31:0] in_rs_val = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        bad_form;
    logic        misalign;
    logic        wb_valid;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    isd_store_unit dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected-value model
    logic [31:0] e_ea, e_wd;
    logic [3:0]  e_be;
    logic        e_bad, e_mis, e_we, e_wb;

    task automatic model(input logic [1:0] sz, input bit idx, input bit upd, input bit rec,
                         input logic [4:0] ra, input logic [15:0] d, input logic [31:0] rav,
                         input logic [31:0] rbv, input logic [31:0] rsv);
        logic [31:0] base;
        logic [1:0]  off;
        base  = (ra == 5'd0) ? 32'd0 : rav;
        e_ea  = idx ? base + rbv : base + {{16{d[15]}}, d};
        off   = e_ea[1:0];
        e_bad = rec || (sz == 2'd3) || (upd && ra == 5'd0);
        e_mis = !e_bad && ((sz == 2'd1 && off[0]) || (sz == 2'd2 && off != 2'd0));
        e_we  = !e_bad && !e_mis;
        e_wb  = e_we && upd;
        case (sz)
            2'd0:    begin e_be = 4'b1000 >> off;                     e_wd = {4{rsv[7:0]}};  end
            2'd1:    begin e_be = off[1] ? 4'b0011 : 4'b1100;          e_wd = {2{rsv[15:0]}}; end
            default: begin e_be = 4'b1111;                             e_wd = rsv;            end
        endcase
        if (!e_we) e_be = 4'b0000;
    endtask

    task automatic drive(input logic [1:0] sz, input bit idx, input bit upd, input bit rec,
                         input logic [4:0] ra, input logic [15:0] d, input logic [31:0] rav,
                         input logic [31:0] rbv, input logic [31:0] rsv);
        in_size = sz; in_indexed = idx; in_update = upd; in_record = rec;
        in_ra_idx = ra; in_disp = d; in_ra_val = rav; in_rb_val = rbv; in_rs_val = rsv;
        in_valid = 1'b1;
    endtask

    task automatic check_result(input bit idx, input logic [1:0] sz, input logic [4:0] ra);
        string atag, btag;
        atag = idx ? "R2 addr" : "R1 addr";
        btag = (sz == 2'd0) ? "R3 be" : (sz == 2'd1) ? "R4 be" : "R5 be";
        chk(out_valid == 1'b1, "R11 out_valid", {31'd0, out_valid}, 32'd1);
        chk(mem_addr == e_ea, atag, mem_addr, e_ea);
        chk(mem_be == e_be, btag, {28'd0, mem_be}, {28'd0, e_be});
        chk(bad_form == e_bad, "R9 bad_form", {31'd0, bad_form}, {31'd0, e_bad});
        chk(misalign == e_mis, "R10 misalign", {31'd0, misalign}, {31'd0, e_mis});
        chk(mem_we == e_we, "R8 mem_we", {31'd0, mem_we}, {31'd0, e_we});
        chk(wb_valid == e_wb, "R6 wb_valid", {31'd0, wb_valid}, {31'd0, e_wb});
        if (e_we) chk(mem_wdata == e_wd, "R3 wdata", mem_wdata, e_wd);
        if (e_wb) begin
            chk(wb_idx == ra, "R6 wb_idx", {27'd0, wb_idx}, {27'd0, ra});
            chk(wb_data == e_ea, "R6 wb_data", wb_data, e_ea);
        end
    endtask

    initial begin
        #(10 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!out_valid && !mem_we && !wb_valid, "R12 reset", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !mem_we && !wb_valid, "R12 after reset", {31'd0, out_valid}, 32'd0);
        chk(in_ready == 1'b1, "R11 ready empty", {31'd0, in_ready}, 32'd1);

        // sweep: size x form x update x record x base index x offset
        for (int sz = 0; sz < 4; sz++)
          for (int idx = 0; idx < 2; idx++)
            for (int upd = 0; upd < 2; upd++)
              for (int rec = 0; rec < 2; rec++)
                for (int rsel = 0; rsel < 2; rsel++)
                  for (int off = 0; off < 4; off++) begin
                      logic [4:0]  ra;
                      logic [15:0] d;
                      logic [31:0] rav, rbv, rsv;
                      ra  = rsel ? 5'd7 : 5'd0;
                      rav = 32'h0001_2340;
                      d   = (off[0] ? 16'hFF00 : 16'h0010) + 16'(off);
                      rbv = 32'h0000_0100 + 32'(off);
                      rsv = 32'hA1B2_C3D4 ^ 32'(sz * 16 + off);
                      @(negedge clk);
                      drive(2'(sz), idx[0], upd[0], rec[0], ra, d, rav, rbv, rsv);
                      model(2'(sz), idx[0], upd[0], rec[0], ra, d, rav, rbv, rsv);
                      @(negedge clk);
                      in_valid = 1'b0;
                      check_result(idx[0], 2'(sz), ra);
                  end

        // R7: source and base are the same register in an update store
        @(negedge clk);
        drive(2'd2, 1'b0, 1'b1, 1'b0, 5'd3, 16'h0008, 32'h0000_4000, 32'd0, 32'h0000_4000);
        model(2'd2, 1'b0, 1'b1, 1'b0, 5'd3, 16'h0008, 32'h0000_4000, 32'd0, 32'h0000_4000);
        @(negedge clk);
        in_valid = 1'b0;
        chk(mem_wdata == 32'h0000_4000, "R7 old data", mem_wdata, 32'h0000_4000);
        chk(wb_valid && wb_data == 32'h0000_4008, "R7 new addr", wb_data, 32'h0000_4008);

        // R11: stall holds result, offered instruction waits
        @(negedge clk);
        out_ready = 1'b0;
        drive(2'd2, 1'b1, 1'b1, 1'b0, 5'd4, 16'h0, 32'h0000_1000, 32'h0000_0020, 32'h1111_2222);
        @(negedge clk);
        drive(2'd0, 1'b0, 1'b0, 1'b0, 5'd9, 16'h0003, 32'h0000_8000, 32'd0, 32'h0000_0055);
        for (int k = 0; k < 3; k++) begin
            chk(out_valid && mem_addr == 32'h0000_1020, "R11 hold addr", mem_addr, 32'h0000_1020);
            chk(!wb_valid, "R11 no wb stalled", {31'd0, wb_valid}, 32'd0);
            chk(!in_ready, "R11 not ready", {31'd0, in_ready}, 32'd0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        #1;
        chk(wb_valid && wb_idx == 5'd4 && wb_data == 32'h0000_1020, "R6 wb on take",
            wb_data, 32'h0000_1020);
        @(negedge clk);
        in_valid = 1'b0;
        chk(mem_addr == 32'h0000_8003 && mem_be == 4'b0001, "R11 next taken",
            mem_addr, 32'h0000_8003);
        chk(mem_wdata == 32'h5555_5555, "R3 replicate", mem_wdata, 32'h5555_5555);
        chk(!wb_valid, "R6 non-update no wb", {31'd0, wb_valid}, 32'd0);
        @(negedge clk);
        chk(!out_valid, "R11 drained", {31'd0, out_valid}, 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule